// File: doc/BRIEF.md
# Pulse-Width Serial Time Code Decoder

This block takes a one-second serial time code on a single asynchronous line and recovers a timestamp from it. Each 10 ms symbol slot holds one high pulse. The length of that pulse, measured in ticks of a sample-rate clock enable, gives the symbol: a short pulse is a data zero, a middle pulse is a data one, and a long pulse is a marker. Markers fall at fixed slots and divide the frame into groups. Two markers in a row mark the frame boundary.

The decoder has three states. **HUNT** waits for a marker and moves to **ARMED** when one arrives. **ARMED** moves to **RUN** if the next symbol is also a marker, and that symbol becomes slot 0. Any other symbol sends ARMED back to HUNT. **RUN** counts slots 0 to 99. It stores the data bits, and when the marker in slot 99 has been measured it range-checks the fields. A good frame gives one valid pulse and stays in RUN for the next frame. Three conditions send RUN back to HUNT: a marker in the wrong slot or a missing marker (frame error), a field out of range (format error), and a pulse width outside the accepted bounds (width error, which applies in any state). The outputs keep the last good timestamp until the next good frame replaces it.

Top module: `tcd_decoder`

## Requirements
- R1: While reset is asserted and right after it, `valid_o`, every error flag, `locked_o` and all timestamp fields are zero.
- R2: The line passes through two synchroniser flops. The high time N is counted in enabled ticks, with P = TICKS_PER_BIT, a multiple of 8. The symbol is a zero when P/8 <= N < 3P/8, a one when 3P/8 <= N < 5P/8, and a marker when 5P/8 <= N <= 7P/8.
- R3: A pulse with N < P/8 or N > 7P/8 raises `err_width_o` for one cycle, in any state, and the decoder returns to HUNT.
- R4: After reset or an error the decoder stays in HUNT until it sees two markers back to back. The second marker is slot 0, and `locked_o` is high while in RUN.
- R5: In RUN a marker is expected at slot 0 and at every slot whose index ends in 9 (9, 19, …, 99). A marker at any other slot, or a non-marker at one of those slots, raises `err_frame_o` for one cycle and returns the decoder to HUNT.
- R6: Field layout, with each group sent least significant bit first and BCD coded: seconds units in slots 1–4, seconds tens in 6–8, minutes units in 10–13, minutes tens in 15–17, day units in 20–23, day tens in 25–28, day hundreds in 30–31, and the status byte in 50–57. `sec_o`/`min_o` = {tens[2:0], units[3:0]} and `day_o` = {hundreds[1:0], tens[3:0], units[3:0]}. Data symbols in any other slot are ignored.
- R7: When the slot-99 marker of a frame in range is measured, `valid_o` pulses for one cycle, together with the new timestamp. This happens on the third rising clock edge after the line falls.
- R8: A frame with seconds or minutes units above 9 or tens above 5, day digits above 9, or a day value outside 1 to 366 gives no valid pulse. It raises `err_format_o` for one cycle and returns the decoder to HUNT.
- R9: Between valid pulses the timestamp outputs keep their last value, including across errors.
- R10: Frames that follow each other are decoded without a new hunt. The slot-99 marker together with the next slot-0 marker keeps the lock.
- R11: At most one of `valid_o`, `err_width_o`, `err_frame_o`, `err_format_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Sample-rate enable that paces the width count |
| code_in | input | 1 | Asynchronous serial time code line |
| valid_o | output | 1 | One-cycle pulse when a new timestamp is presented |
| sec_o | output | 7 | Seconds, BCD {tens, units} |
| min_o | output | 7 | Minutes, BCD {tens, units} |
| day_o | output | 10 | Day of year, BCD {hundreds, tens, units} |
| status_o | output | 8 | Status byte |
| locked_o | output | 1 | High while frame-locked (RUN) |
| err_width_o | output | 1 | One-cycle pulse: pulse width out of bounds |
| err_frame_o | output | 1 | One-cycle pulse: marker missing or misplaced |
| err_format_o | output | 1 | One-cycle pulse: decoded field out of range |

## Verification
The hardest situations to reach are the re-entries into lock after an error. The decoder must skip the ARMED/HUNT alternations that follow a misplaced marker and then lock again on the slot-99/slot-0 pair at the end of the broken frame. After a format error, one extra marker must be sent before the next frame can be decoded. The stimulus sends whole frames with one slot's pulse width replaced (an early marker, a missing marker, a runt pulse and an over-long pulse), along with frames carrying out-of-range days and tens digits, in sequences chosen so that each of these recovery paths is taken. A behavioural symbol-level model predicts every output pulse and the lock state, and the outputs are compared with it on every clock.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    localparam int SLOTS = 100;

    typedef enum logic [1:0] {
        SYM_ZERO,
        SYM_ONE,
        SYM_MARK,
        SYM_BAD
    } sym_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_ARMED,
        ST_RUN
    } state_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [9:0] day;
        logic [7:0] status;
    } stamp_t;

endpackage

// File: rtl/tcd_sync.sv
module tcd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/tcd_width.sv
module tcd_width
    import tcd_pkg::*;
#(
    parameter int TICKS_PER_BIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic level_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic sym_vld_o,
    output sym_e sym_o
);
    localparam int CW = $clog2(TICKS_PER_BIT) + 2;
    localparam logic [CW-1:0] LIM_MIN = CW'(TICKS_PER_BIT / 8);
    localparam logic [CW-1:0] LIM_01  = CW'(3 * TICKS_PER_BIT / 8);
    localparam logic [CW-1:0] LIM_1M  = CW'(5 * TICKS_PER_BIT / 8);
    localparam logic [CW-1:0] LIM_MAX = CW'(7 * TICKS_PER_BIT / 8);
    localparam logic [CW-1:0] CMAX    = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            cnt_q <= tick_en ? CW'(1) : '0;
        end else if (level_i && tick_en && cnt_q != CMAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        sym_vld_o = fall_i;
        if (cnt_q < LIM_MIN)       sym_o = SYM_BAD;
        else if (cnt_q < LIM_01)   sym_o = SYM_ZERO;
        else if (cnt_q < LIM_1M)   sym_o = SYM_ONE;
        else if (cnt_q <= LIM_MAX) sym_o = SYM_MARK;
        else                       sym_o = SYM_BAD;
    end

    // R2
    sym_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld_o |-> $past(level_i));

endmodule

// File: rtl/tcd_fields.sv
module tcd_fields
    import tcd_pkg::*;
(
    input  logic [SLOTS-1:0] bits_i,
    output stamp_t           stamp_o,
    output logic             ok_o
);
    function automatic logic [7:0] grab(input logic [SLOTS-1:0] b, input int lo, input int n);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < n) r[i] = b[lo + i];
        end
        return r;
    endfunction

    logic [3:0] su, mu, du, dt;
    logic [2:0] st, mt;
    logic [1:0] dh;
    logic [7:0] stat;
    logic [9:0] dayv;
    logic       unused_bits;

    assign su   = grab(bits_i, 1, 4)[3:0];
    assign st   = grab(bits_i, 6, 3)[2:0];
    assign mu   = grab(bits_i, 10, 4)[3:0];
    assign mt   = grab(bits_i, 15, 3)[2:0];
    assign du   = grab(bits_i, 20, 4)[3:0];
    assign dt   = grab(bits_i, 25, 4)[3:0];
    assign dh   = grab(bits_i, 30, 2)[1:0];
    assign stat = grab(bits_i, 50, 8);
    assign unused_bits = ^bits_i;

    assign dayv = 10'(dh) * 10'd100 + 10'(dt) * 10'd10 + 10'(du);

    assign ok_o = (su <= 4'd9) && (st <= 3'd5) && (mu <= 4'd9) && (mt <= 3'd5)
               && (du <= 4'd9) && (dt <= 4'd9) && (dayv != 10'd0) && (dayv <= 10'd366);

    assign stamp_o = '{sec: {st, su}, min: {mt, mu}, day: {dh, dt, du}, status: stat};

endmodule

// File: rtl/tcd_decoder.sv
module tcd_decoder
    import tcd_pkg::*;
#(
    parameter int TICKS_PER_BIT = 100,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       code_in,
    output logic       valid_o,
    output logic [6:0] sec_o,
    output logic [6:0] min_o,
    output logic [9:0] day_o,
    output logic [7:0] status_o,
    output logic       locked_o,
    output logic       err_width_o,
    output logic       err_frame_o,
    output logic       err_format_o
);
    localparam int SW = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic level, rise, fall, sym_vld, fmt_ok;
    sym_e sym;
    stamp_t fields, stamp_q;

    state_e state_q, state_d;
    logic [SW-1:0] slot_q, slot_d;
    logic [SLOTS-1:0] data_q;
    logic mark_due, store;
    logic fire_v, fire_w, fire_f, fire_m;

    tcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(code_in),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    tcd_width #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_width (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .level_i(level), .rise_i(rise), .fall_i(fall),
        .sym_vld_o(sym_vld), .sym_o(sym)
    );

    tcd_fields u_fields (
        .bits_i(data_q), .stamp_o(fields), .ok_o(fmt_ok)
    );

    assign mark_due = (slot_q == '0) || ((slot_q % SW'(10)) == SW'(9));

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        store   = 1'b0;
        fire_v  = 1'b0;
        fire_w  = 1'b0;
        fire_f  = 1'b0;
        fire_m  = 1'b0;
        if (sym_vld) begin
            if (sym == SYM_BAD) begin
                fire_w  = 1'b1;
                state_d = ST_HUNT;
            end else begin
                unique case (state_q)
                    ST_HUNT: begin
                        if (sym == SYM_MARK) state_d = ST_ARMED;
                    end
                    ST_ARMED: begin
                        if (sym == SYM_MARK) begin
                            state_d = ST_RUN;
                            slot_d  = SW'(1);
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end
                    ST_RUN: begin
                        if (mark_due != (sym == SYM_MARK)) begin
                            fire_f  = 1'b1;
                            state_d = ST_HUNT;
                        end else if (slot_q == LAST_SLOT) begin
                            slot_d = '0;
                            if (fmt_ok) begin
                                fire_v = 1'b1;
                            end else begin
                                fire_m  = 1'b1;
                                state_d = ST_HUNT;
                            end
                        end else begin
                            slot_d = slot_q + SW'(1);
                            store  = !mark_due;
                        end
                    end
                    default: state_d = ST_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            slot_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            if (store) data_q[slot_q] <= (sym == SYM_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o      <= 1'b0;
            err_width_o  <= 1'b0;
            err_frame_o  <= 1'b0;
            err_format_o <= 1'b0;
            stamp_q      <= '0;
        end else begin
            valid_o      <= fire_v;
            err_width_o  <= fire_w;
            err_frame_o  <= fire_f;
            err_format_o <= fire_m;
            if (fire_v) stamp_q <= fields;
        end
    end

    assign locked_o = (state_q == ST_RUN);
    assign sec_o    = stamp_q.sec;
    assign min_o    = stamp_q.min;
    assign day_o    = stamp_q.day;
    assign status_o = stamp_q.status;

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, err_width_o, err_frame_o, err_format_o}));

    // R7
    valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(state_q == ST_RUN));

    // R9
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable({sec_o, min_o, day_o, status_o}));

    // R5
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame_o |-> !locked_o);

    // R4
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(state_q == ST_ARMED));

    // R5
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST_SLOT);

endmodule

// File: tb/tcd_decoder_test.sv
module tcd_decoder_test;

    localparam int P = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic code_in = 1'b0;
    logic valid_o, locked_o, err_width_o, err_frame_o, err_format_o;
    logic [6:0] sec_o, min_o;
    logic [9:0] day_o;
    logic [7:0] status_o;

    tcd_decoder #(.TICKS_PER_BIT(P)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .code_in(code_in),
        .valid_o(valid_o), .sec_o(sec_o), .min_o(min_o), .day_o(day_o),
        .status_o(status_o), .locked_o(locked_o), .err_width_o(err_width_o),
        .err_frame_o(err_frame_o), .err_format_o(err_format_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int valid_cnt = 0;
    bit compare_on = 0;
    bit finished = 0;

    typedef struct {
        int at;
        bit v, ew, ef, em, lk;
        logic [31:0] stamp;
    } ev_t;
    ev_t evq[$];

    int m_state = 0;
    int m_slot = 0;
    bit m_bits[100];
    bit e_lk = 0;
    logic [31:0] e_stamp = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int dig(input int lo, input int n);
        int r = 0;
        for (int i = 0; i < n; i++) if (m_bits[lo + i]) r += (1 << i);
        return r;
    endfunction

    task automatic model_sym(input int w, input int c);
        ev_t e;
        int cls;
        bit due;
        e.at = c + 3; e.v = 0; e.ew = 0; e.ef = 0; e.em = 0; e.stamp = '0;
        if (w * 8 < P) cls = 3;
        else if (w * 8 < 3 * P) cls = 0;
        else if (w * 8 < 5 * P) cls = 1;
        else if (w * 8 <= 7 * P) cls = 2;
        else cls = 3;
        if (cls == 3) begin
            e.ew = 1; m_state = 0;
        end else if (m_state == 0) begin
            if (cls == 2) m_state = 1;
        end else if (m_state == 1) begin
            if (cls == 2) begin m_state = 2; m_slot = 1; end
            else m_state = 0;
        end else begin
            due = (m_slot == 0) || (m_slot % 10 == 9);
            if (due != (cls == 2)) begin
                e.ef = 1; m_state = 0;
            end else if (m_slot == 99) begin
                int su, st, mu, mt, du, dt, dh, sb, dv;
                su = dig(1, 4); st = dig(6, 3); mu = dig(10, 4); mt = dig(15, 3);
                du = dig(20, 4); dt = dig(25, 4); dh = dig(30, 2); sb = dig(50, 8);
                dv = dh * 100 + dt * 10 + du;
                m_slot = 0;
                if (su <= 9 && st <= 5 && mu <= 9 && mt <= 5 && du <= 9 && dt <= 9
                    && dv >= 1 && dv <= 366) begin
                    e.v = 1;
                    e.stamp = {st[2:0], su[3:0], mt[2:0], mu[3:0],
                               dh[1:0], dt[3:0], du[3:0], sb[7:0]};
                end else begin
                    e.em = 1; m_state = 0;
                end
            end else begin
                if (!due) m_bits[m_slot] = (cls == 1);
                m_slot++;
            end
        end
        e.lk = (m_state == 2);
        evq.push_back(e);
    endtask

    always @(negedge clk) begin
        bit pv, pw, pf, pm;
        pv = 0; pw = 0; pf = 0; pm = 0;
        if (compare_on) begin
            if (evq.size() > 0 && evq[0].at == cyc) begin
                ev_t e;
                e = evq.pop_front();
                pv = e.v; pw = e.ew; pf = e.ef; pm = e.em; e_lk = e.lk;
                if (e.v) e_stamp = e.stamp;
            end
            chk(valid_o == pv, "R7", "valid pulse", valid_o, pv);
            chk(err_width_o == pw, "R3", "width error", err_width_o, pw);
            chk(err_frame_o == pf, "R5", "frame error", err_frame_o, pf);
            chk(err_format_o == pm, "R8", "format error", err_format_o, pm);
            chk(locked_o == e_lk, "R4", "lock state", locked_o, e_lk);
            chk({sec_o, min_o, day_o, status_o} == e_stamp, "R9", "timestamp",
                {sec_o, min_o, day_o, status_o}, e_stamp);
            chk($countones({valid_o, err_width_o, err_frame_o, err_format_o}) <= 1,
                "R11", "pulse exclusivity",
                {valid_o, err_width_o, err_frame_o, err_format_o}, 0);
            if (valid_o) valid_cnt++;
        end
    end

    task automatic send_sym(input int w);
        @(negedge clk);
        code_in = 1'b1;
        repeat (w) @(negedge clk);
        code_in = 1'b0;
        model_sym(w, cyc);
        repeat (P - w - 1) @(negedge clk);
    endtask

    function automatic void put(ref bit b[100], input int lo, input int n, input int v);
        for (int i = 0; i < n; i++) b[lo + i] = v[i];
    endfunction

    task automatic send_frame(input int s, input int m, input int d, input int st,
                              input int bad_slot, input int bad_w);
        bit b[100];
        for (int k = 0; k < 100; k++) b[k] = 0;
        put(b, 1, 4, s % 10);  put(b, 6, 3, s / 10);
        put(b, 10, 4, m % 10); put(b, 15, 3, m / 10);
        put(b, 20, 4, d % 10); put(b, 25, 4, (d / 10) % 10); put(b, 30, 2, d / 100);
        put(b, 50, 8, st);
        for (int k = 0; k < 100; k++) begin
            int w;
            w = (k == 0 || k % 10 == 9) ? 12 : (b[k] ? 8 : 4);
            if (k == bad_slot) w = bad_w;
            send_sym(w);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 200000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({valid_o, err_width_o, err_frame_o, err_format_o, locked_o} == 5'b0,
            "R1", "flags in reset", {valid_o, err_width_o, err_frame_o, err_format_o, locked_o}, 0);
        chk({sec_o, min_o, day_o, status_o} == 32'h0, "R1", "fields in reset",
            {sec_o, min_o, day_o, status_o}, 0);
        rst_n = 1'b1;
        compare_on = 1;
        @(negedge clk);
        chk(locked_o == 1'b0, "R1", "lock after reset", locked_o, 0);

        // R4: data symbols in HUNT are ignored, then a double marker locks
        send_sym(4); send_sym(8); send_sym(4);
        send_sym(12);
        send_frame(37, 52, 245, 8'hA5, -1, 0);
        repeat (4) @(negedge clk);
        chk(sec_o == 7'h37, "R2", "seconds after first frame", sec_o, 7'h37);
        chk(day_o == 10'h245, "R6", "day after first frame", day_o, 10'h245);
        chk(status_o == 8'hA5, "R6", "status after first frame", status_o, 8'hA5);

        // R10: back-to-back frame, upper bounds
        send_frame(59, 0, 366, 8'h3C, -1, 0);
        repeat (4) @(negedge clk);
        chk(valid_cnt == 2, "R10", "consecutive frames decoded", valid_cnt, 2);
        chk(day_o == 10'h366, "R10", "day 366 accepted", day_o, 10'h366);

        // R8: day 367 rejected
        send_frame(12, 34, 367, 8'h00, -1, 0);
        send_sym(12);
        // lower bound day 1, minutes 59
        send_frame(0, 59, 1, 8'h01, -1, 0);
        repeat (4) @(negedge clk);
        chk(min_o == 7'h59, "R8", "minutes 59 accepted", min_o, 7'h59);

        // R5: early marker, then missing marker
        send_frame(20, 30, 100, 8'h00, 5, 12);
        send_frame(8, 8, 8, 8'h80, 19, 4);
        // R3: runt pulse, then over-long pulse
        send_frame(45, 17, 200, 8'hFF, 40, 1);
        send_frame(45, 17, 200, 8'hFF, 60, 15);
        // R8: day zero, then seconds tens digit 6
        send_frame(0, 0, 0, 8'h00, -1, 0);
        send_sym(12);
        send_frame(61, 0, 10, 8'h00, -1, 0);
        repeat (4) @(negedge clk);
        chk(day_o == 10'h001, "R9", "timestamp held over errors", day_o, 10'h001);
        send_sym(12);
        send_frame(1, 1, 1, 8'h55, -1, 0);
        repeat (6) @(negedge clk);
        chk(status_o == 8'h55, "R6", "final status", status_o, 8'h55);
        chk(evq.size() == 0, "R7", "all predicted events seen", evq.size(), 0);
        finished = 1;
        finish_run();
    end

endmodule